// File: doc/BRIEF.md
# Programmable Duty Clock Channel Divider

This block divides an input clock by an integer ratio from 2 to 32. The high time and the low time of the divided clock are programmed separately, as N+1 and M+1 input cycles. A bypass mode passes the input clock through unchanged, which gives divide-by-one. A synchronization input holds the channel quiet. When that input is released, the channel waits a programmable number of input cycles (0 to 31) and then starts at a programmed level. A "running" flag marks the point from which output edges are produced.

For odd ratios where the low count is one more than the high count, an optional correction stage stretches each high phase by half an input cycle. A copy of the output retimed on the falling edge is ORed onto the output, which brings the duty cycle to 50%. The configuration inputs are static. They are captured only while sync is asserted, so a new setting takes effect at the next release. A setting that cannot be built is forced into range before it is stored.

Top module: `chdiv_channel`

## Requirements
- R1: After reset, and until the first release of sync, `div_clk_o` and `running_o` stay low. This holds whatever the configuration inputs are, bypass included.
- R2: While running, the output is high for N+1 input cycles and low for M+1 input cycles, so the period is D = N+M+2. N is `high_cnt_i` and M is `low_cnt_i`.
- R3: Call E0 the first rising clock edge at which sync is sampled low after having been high. The output takes its start level at rising edge E0+P, where P is `phase_cnt_i` (0 to 31). `running_o` rises at that same edge.
- R4: The first phase after the delay has the start level. When `start_high_i`=1 it is a high phase of N+1 cycles. When `start_high_i`=0 it is a low phase of M+1 cycles.
- R5: Once sync is sampled high at a rising edge, `running_o` is low after that edge. The output is low by the following falling edge and stays low until the next release.
- R6: Configuration inputs are stored only at rising edges where sync is high. Changing them while sync is low has no effect on the output.
- R7: If N+M > 30, the stored counts become N' = min(N,30) and M' = 30 - N', so the period saturates at 32.
- R8: With correction enabled, bypass off and M = N+1, each high phase ends half an input cycle later. It falls at the falling edge that follows the rising edge where the uncorrected output would fall.
- R9: With correction enabled but M ≠ N+1 (after R7 is applied), correction is turned off and the output is as in R2.
- R10: In bypass, the output equals the input clock from the first rising edge after `running_o` is high. Outside of running it is held low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Divider input clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| sync_i | input | 1 | Hold request; release starts the channel |
| high_cnt_i | input | 5 | N: high time is N+1 input cycles |
| low_cnt_i | input | 5 | M: low time is M+1 input cycles |
| phase_cnt_i | input | 5 | Start delay in input cycles after release |
| start_high_i | input | 1 | 1: first phase high, 0: first phase low |
| bypass_i | input | 1 | Pass the input clock through (divide-by-one) |
| dcc_en_i | input | 1 | Enable half-cycle duty correction |
| div_clk_o | output | 1 | Divided clock |
| running_o | output | 1 | Start delay expired, output active |

## Verification
Two functions can act at the same rising edge. The first is a sync assertion. The second is either the high-to-low switch of the counters or the half-cycle stretch of the correction stage. Each case runs for a fixed P+2D+4 edges before the next case raises sync. With random N, M and P, sync therefore lands at arbitrary points in the phase, including on a toggle edge. The bench samples the output at both clock levels. It requires the stretched high half to be gone by the next falling edge after sync is captured, and the output to read low a full cycle later.

// File: rtl/chdiv_pkg.sv
// Shared types for the clock-channel divider.
// Assumes: count fields are CW bits wide, large enough for a 0..31 range.
package chdiv_pkg;
    localparam int CW = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_RUN   = 2'd2
    } chdiv_state_e;

    typedef struct packed {
        logic [CW-1:0] high;
        logic [CW-1:0] low;
        logic [CW-1:0] phase;
        logic          start_high;
        logic          dcc;
        logic          bypass;
    } chdiv_cfg_t;
endpackage

// File: rtl/chdiv_cfg_capture.sv
// Legalises the raw configuration and stores it while sync is high.
// Assumes: MAX_RATIO <= 2**CW + 1 so that MAX_RATIO-2 fits in a count field.
module chdiv_cfg_capture
    import chdiv_pkg::*;
#(
    parameter int MAX_RATIO = 32
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       sync_i,
    input  chdiv_cfg_t raw_i,
    output chdiv_cfg_t eff_o
);
    localparam int SUM_MAX = MAX_RATIO - 2;

    logic [CW:0]   raw_sum;
    logic [CW-1:0] high_sat;
    chdiv_cfg_t    legal;

    assign raw_sum  = {1'b0, raw_i.high} + {1'b0, raw_i.low};
    assign high_sat = (int'(raw_i.high) > SUM_MAX) ? CW'(SUM_MAX) : raw_i.high;

    // Saturate an over-long period and drop correction if counts do not suit it.
    always_comb begin
        legal = raw_i;
        if (int'(raw_sum) > SUM_MAX) begin
            legal.high = high_sat;
            legal.low  = CW'(SUM_MAX) - high_sat;
        end
        legal.dcc = raw_i.dcc &&
                    ({1'b0, legal.low} == ({1'b0, legal.high} + {{CW{1'b0}}, 1'b1}));
    end

    // Store the legalised setting only while the channel is held in sync.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            eff_o <= '0;
        end else if (sync_i) begin
            eff_o <= legal;
        end
    end
endmodule

// File: rtl/chdiv_core.sv
// Rising-edge divider core: start delay, then alternating high/low phases.
// Assumes: cfg_i is stable whenever sync_i is low (guaranteed by capture stage).
module chdiv_core
    import chdiv_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       sync_i,
    input  chdiv_cfg_t cfg_i,
    output logic       lvl_o,
    output logic       run_o
);
    chdiv_state_e  st_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] first_cnt;
    logic          armed_q;

    assign first_cnt = cfg_i.start_high ? cfg_i.high : cfg_i.low;

    // Sequence idle -> delay -> run; each phase counts its length down to zero.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            lvl_o   <= 1'b0;
            run_o   <= 1'b0;
            armed_q <= 1'b0;
        end else if (sync_i) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            lvl_o   <= 1'b0;
            run_o   <= 1'b0;
            armed_q <= 1'b1;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (armed_q) begin
                        armed_q <= 1'b0;
                        if (cfg_i.phase == '0) begin
                            st_q  <= ST_RUN;
                            run_o <= 1'b1;
                            lvl_o <= cfg_i.start_high;
                            cnt_q <= first_cnt;
                        end else begin
                            st_q  <= ST_DELAY;
                            cnt_q <= cfg_i.phase - CW'(1);
                        end
                    end
                end
                ST_DELAY: begin
                    if (cnt_q == '0) begin
                        st_q  <= ST_RUN;
                        run_o <= 1'b1;
                        lvl_o <= cfg_i.start_high;
                        cnt_q <= first_cnt;
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                ST_RUN: begin
                    if (cnt_q == '0) begin
                        lvl_o <= ~lvl_o;
                        cnt_q <= lvl_o ? cfg_i.low : cfg_i.high;
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/chdiv_outstage.sv
// Output stage: optional half-cycle duty stretch and the bypass clock gate.
// Assumes: lvl_i and run_i change only on rising edges of clk_i.
module chdiv_outstage #(
    parameter bit DCC_PRESENT = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    input  logic run_i,
    input  logic dcc_en_i,
    input  logic bypass_i,
    output logic clk_o
);
    logic run_n;
    logic shaped;

    // Falling-edge copy of run, so the bypass gate opens and closes while clk is low.
    always_ff @(negedge clk_i) begin
        if (!rst_ni) begin
            run_n <= 1'b0;
        end else begin
            run_n <= run_i;
        end
    end

    if (DCC_PRESENT) begin : g_dcc
        logic lvl_n;

        // Falling-edge retimed level, ORed on to stretch each high phase.
        always_ff @(negedge clk_i) begin
            if (!rst_ni) begin
                lvl_n <= 1'b0;
            end else begin
                lvl_n <= lvl_i;
            end
        end

        assign shaped = dcc_en_i ? (lvl_i | lvl_n) : lvl_i;
    end else begin : g_no_dcc
        assign shaped = lvl_i;
    end

    assign clk_o = bypass_i ? (clk_i & run_n) : shaped;
endmodule

// File: rtl/chdiv_channel.sv
// Top of one clock-channel divider: capture, counting core and output stage.
// Assumes: configuration ports are static and only sampled while sync_i is high.
module chdiv_channel
    import chdiv_pkg::*;
#(
    parameter int MAX_RATIO   = 32,
    parameter bit DCC_PRESENT = 1'b1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          sync_i,
    input  logic [CW-1:0] high_cnt_i,
    input  logic [CW-1:0] low_cnt_i,
    input  logic [CW-1:0] phase_cnt_i,
    input  logic          start_high_i,
    input  logic          bypass_i,
    input  logic          dcc_en_i,
    output logic          div_clk_o,
    output logic          running_o
);
    chdiv_cfg_t raw_cfg;
    chdiv_cfg_t eff_cfg;
    logic       core_lvl;
    logic       core_run;

    // Bundle the configuration ports into one record.
    always_comb begin
        raw_cfg.high       = high_cnt_i;
        raw_cfg.low        = low_cnt_i;
        raw_cfg.phase      = phase_cnt_i;
        raw_cfg.start_high = start_high_i;
        raw_cfg.dcc        = dcc_en_i;
        raw_cfg.bypass     = bypass_i;
    end

    chdiv_cfg_capture #(.MAX_RATIO(MAX_RATIO)) u_cfg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sync_i (sync_i),
        .raw_i  (raw_cfg),
        .eff_o  (eff_cfg)
    );

    chdiv_core u_core (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sync_i (sync_i),
        .cfg_i  (eff_cfg),
        .lvl_o  (core_lvl),
        .run_o  (core_run)
    );

    chdiv_outstage #(.DCC_PRESENT(DCC_PRESENT)) u_out (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .lvl_i    (core_lvl),
        .run_i    (core_run),
        .dcc_en_i (eff_cfg.dcc),
        .bypass_i (eff_cfg.bypass),
        .clk_o    (div_clk_o)
    );

    assign running_o = core_run;
endmodule

// File: rtl/chdiv_channel_chk.sv
// Checker for chdiv_channel: phase lengths, sync hold, start level, config rules.
// Assumes: bound into chdiv_channel with the default MAX_RATIO.
module chdiv_channel_chk
    import chdiv_pkg::*;
#(
    parameter int MAX_RATIO = 32
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       sync_i,
    input logic       running_o,
    input logic       lvl_q,
    input chdiv_cfg_t eff
);
    localparam int SUM_MAX = MAX_RATIO - 2;

    logic [CW:0] hi_len;
    logic [CW:0] lo_len;

    // Count consecutive running cycles spent at each level.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            hi_len <= '0;
            lo_len <= '0;
        end else begin
            hi_len <= (running_o && lvl_q && (&hi_len == 1'b0)) ? hi_len + 1'b1 :
                      (running_o && lvl_q) ? hi_len : '0;
            lo_len <= (running_o && !lvl_q && (&lo_len == 1'b0)) ? lo_len + 1'b1 :
                      (running_o && !lvl_q) ? lo_len : '0;
        end
    end

    AST_HIGH_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running_o && $past(running_o) && !lvl_q && $past(lvl_q))
        |-> (hi_len == {1'b0, eff.high} + 1'b1)); // R2

    AST_LOW_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running_o && $past(running_o) && lvl_q && !$past(lvl_q))
        |-> (lo_len == {1'b0, eff.low} + 1'b1)); // R2

    AST_RUN_AFTER_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(running_o) |-> !$past(sync_i)); // R3

    AST_START_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(running_o) |-> (lvl_q == eff.start_high)); // R4

    AST_SYNC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_i |=> (!running_o && !lvl_q)); // R5

    AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sync_i |=> ($stable(eff.high) && $stable(eff.low) && $stable(eff.start_high))); // R6

    AST_RATIO_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(eff.high) + int'(eff.low) <= SUM_MAX)); // R7

    AST_DCC_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eff.dcc |-> (int'(eff.low) == int'(eff.high) + 1)); // R9
endmodule

bind chdiv_channel chdiv_channel_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (sync_i),
    .running_o (running_o),
    .lvl_q     (core_lvl),
    .eff       (eff_cfg)
);

// File: tb/sim_chdiv_channel.sv
module sim_chdiv_channel;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync = 1'b0;
    logic [4:0] hi_cnt = '0;
    logic [4:0] lo_cnt = '0;
    logic [4:0] ph_cnt = '0;
    logic       st_hi = 1'b0;
    logic       byp = 1'b0;
    logic       dcc = 1'b0;
    logic       dout;
    logic       run;

    int checks = 0;
    int errors = 0;

    // Model of the active case, derived from the requirements.
    int m_eh, m_el, m_p, m_d;
    bit m_st, m_dcc, m_bp;

    chdiv_channel u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .sync_i       (sync),
        .high_cnt_i   (hi_cnt),
        .low_cnt_i    (lo_cnt),
        .phase_cnt_i  (ph_cnt),
        .start_high_i (st_hi),
        .bypass_i     (byp),
        .dcc_en_i     (dcc),
        .div_clk_o    (dout),
        .running_o    (run)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Level after rising edge j (j=0 is E0), per R2/R3/R4.
    function automatic bit lvl_at(input int j);
        int r;
        if (j < 0 || j < m_p) return 1'b0;
        r = (j - m_p) % m_d;
        return m_st ? (r <= m_eh) : (r > m_el);
    endfunction

    function automatic bit exp_high_half(input int j);
        if (m_bp) return (j - 1 >= 0) && (j - 1 >= m_p);     // R10
        if (m_dcc) return lvl_at(j) | lvl_at(j - 1);         // R8
        return lvl_at(j);
    endfunction

    function automatic bit exp_low_half(input int j);
        if (m_bp) return 1'b0;                               // R10
        return lvl_at(j);
    endfunction

    task automatic run_case(input int n, input int m, input int p,
                            input bit st, input bit dc, input bit bp);
        // R7 saturation and R9 legality
        m_eh = n; m_el = m;
        if (n + m > 30) begin
            m_eh = (n > 30) ? 30 : n;
            m_el = 30 - m_eh;
        end
        m_d = m_eh + m_el + 2;
        m_p = p; m_st = st; m_bp = bp;
        m_dcc = dc && (m_el == m_eh + 1);

        @(negedge clk);
        hi_cnt = 5'(n); lo_cnt = 5'(m); ph_cnt = 5'(p);
        st_hi = st; dcc = dc; byp = bp; sync = 1'b1;
        @(posedge clk); #2;
        chk(run, 1'b0, "R5", "running after sync");
        @(negedge clk); #2;
        chk(dout, 1'b0, "R5", "output at low half after sync");
        @(posedge clk); #2;
        chk(dout, 1'b0, "R5", "output one cycle into sync");
        @(negedge clk);
        sync = 1'b0;
        for (int j = 0; j < p + 2 * m_d + 4; j++) begin
            @(posedge clk); #2;
            chk(dout, exp_high_half(j), m_bp ? "R10" : (m_dcc ? "R8" : "R2"), "high half");
            chk(run, (j >= p), "R3", "running");
            @(negedge clk);
            if (j == 2) begin
                // R6: scramble the inputs while running; output must not change
                hi_cnt = 5'($urandom); lo_cnt = 5'($urandom); ph_cnt = 5'($urandom);
                st_hi = 1'($urandom); dcc = 1'($urandom); byp = 1'($urandom);
            end
            #2;
            chk(dout, exp_low_half(j), (j == p) ? "R4" : "R6", "low half");
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: got hung expected finish");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: no sync yet; nothing runs even in bypass
        hi_cnt = 5'd1; lo_cnt = 5'd1; byp = 1'b1; dcc = 1'b1; st_hi = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk); #2;
            chk(dout, 1'b0, "R1", "output before first sync");
            chk(run, 1'b0, "R1", "running before first sync");
            @(negedge clk); #2;
            chk(dout, 1'b0, "R1", "output low half before first sync");
        end
        // directed corners
        run_case(0, 3, 2, 1'b1, 1'b0, 1'b0);   // R2 div5 1 high 4 low
        run_case(2, 1, 0, 1'b1, 1'b0, 1'b0);   // R2 div5 3 high 2 low
        run_case(0, 0, 0, 1'b0, 1'b0, 1'b0);   // R2 divide by 2, start low R4
        run_case(15, 15, 31, 1'b1, 1'b0, 1'b0); // R3 max delay, D=32
        run_case(2, 3, 1, 1'b1, 1'b1, 1'b0);   // R8 corrected div7
        run_case(2, 3, 4, 1'b0, 1'b1, 1'b0);   // R8 corrected, start low
        run_case(2, 2, 0, 1'b1, 1'b1, 1'b0);   // R9 correction ignored
        run_case(20, 20, 3, 1'b1, 1'b0, 1'b0); // R7 saturation
        run_case(31, 31, 0, 1'b0, 1'b1, 1'b0); // R7 both max
        run_case(4, 4, 0, 1'b1, 1'b0, 1'b1);   // R10 bypass no delay
        run_case(4, 4, 3, 1'b0, 1'b1, 1'b1);   // R10 bypass with delay
        // constrained random
        for (int c = 0; c < 40; c++) begin
            int n, m;
            bit pick_dcc;
            n = int'($urandom % 32);
            pick_dcc = 1'($urandom);
            m = pick_dcc ? ((n + 1) % 32) : int'($urandom % 32);
            run_case(n, m, int'($urandom % 32), 1'($urandom), pick_dcc | 1'($urandom),
                     ($urandom % 8) == 0);
        end
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule